// File: doc/BRIEF.md
# Selectable-Source Interrupt Pin Controller

This block drives a single active-low interrupt pin from two kinds of source. The first is a vector of pending status bits, each paired with an enable bit. The second is a start-of-frame (SOF) event strobe, which the block captures in a sticky flag. An acknowledge strobe clears that flag.

Two stored configuration bits choose which sources may pull the pin low. In the status mode, only enabled pending bits count. In the combined mode, both enabled pending bits and the latched SOF count. The SOF-only bit has priority over the pin-mode bit: when it is set, only the latched SOF counts, whatever the pin-mode bit holds. Both configuration bits load together on a write strobe.

The pin is driven from a two-state machine. In state `PIN_IDLE` the pin is high. In state `PIN_ACTIVE` the pin is low. Transition `RAISE` moves from `PIN_IDLE` to `PIN_ACTIVE` when the selected request is present. Transition `RELEASE` moves from `PIN_ACTIVE` to `PIN_IDLE` when the request is gone. In every other case the state holds.

Top module: `irq_pin_ctrl`

## Requirements
- R1: After reset, `int_n` is 1, and both configuration bits are 0 (status mode).
- R2: The status request is the OR over all bit positions of `status_pend & status_en`. A pending bit whose enable is 0 has no effect on `int_n`.
- R3: When `sof_only` is 0 and `pin_mode` is 0, only the status request can drive `int_n` to 0. A latched SOF is ignored.
- R4: When `sof_only` is 0 and `pin_mode` is 1, either the status request or a latched SOF drives `int_n` to 0.
- R5: When `sof_only` is 1, only a latched SOF drives `int_n` to 0. This holds for both values of `pin_mode`, and pending enabled status bits are ignored.
- R6: A one-cycle `sof_pulse` sets a sticky flag that stays set until `sof_ack` is applied. If `sof_pulse` and `sof_ack` arrive in the same cycle, the flag ends up set.
- R7: `int_n` is registered. It reflects the selected request one clock edge after that request changes, and it stays low while the request persists.
- R8: `cfg_sof_only` and `cfg_pin_mode` are stored only on a clock edge where `cfg_we` is 1. On other edges, changes on those inputs have no effect.
- R9: The SOF flag is captured in every mode. An SOF latched while in status mode shows on `int_n` once the mode is changed to combined, unless the flag was acknowledged first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_pend | input | N_STATUS | Pending status bits |
| status_en | input | N_STATUS | Per-bit enable for the status bits |
| sof_pulse | input | 1 | Start-of-frame event strobe |
| sof_ack | input | 1 | Clears the latched SOF flag |
| cfg_we | input | 1 | Loads the two configuration bits |
| cfg_sof_only | input | 1 | SOF-only configuration value |
| cfg_pin_mode | input | 1 | Pin-mode configuration value |
| int_n | output | 1 | Active-low interrupt output |

## Verification
The status request is combinational, so a change on `status_pend` or `status_en` appears on `int_n` after exactly one clock edge. The SOF path and the configuration path each add a stored stage, so `sof_pulse`, `sof_ack` and `cfg_we` act on `int_n` after two edges. The bench drives every input on the falling edge of the clock and samples `int_n` on a later falling edge. Each check is placed after the right number of rising edges for its path. For the one-edge path, the bench also confirms that `int_n` has not yet changed before that edge.

// File: rtl/irqp_pkg.sv
package irqp_pkg;

    typedef enum logic [1:0] {
        MODE_STATUS = 2'd0,
        MODE_BOTH   = 2'd1,
        MODE_SOF    = 2'd2
    } irq_mode_e;

    typedef enum logic {
        PIN_IDLE   = 1'b0,
        PIN_ACTIVE = 1'b1
    } pin_state_e;

    typedef struct packed {
        logic sof_only;
        logic pin_mode;
    } irq_cfg_t;

    // The SOF-only bit has priority; pin_mode is a don't-care when it is set.
    function automatic irq_mode_e decode_mode(irq_cfg_t cfg);
        if (cfg.sof_only)
            return MODE_SOF;
        else if (cfg.pin_mode)
            return MODE_BOTH;
        else
            return MODE_STATUS;
    endfunction

endpackage

// File: rtl/irqp_mode_reg.sv
module irqp_mode_reg
    import irqp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      we,
    input  irq_cfg_t  cfg_d,
    output irq_mode_e mode
);
    irq_cfg_t cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (we)
            cfg_q <= cfg_d;
    end

    always_comb mode = decode_mode(cfg_q);

    // R8: the stored configuration moves only on a write
    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(cfg_q));
    assert_cfg_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (cfg_q == $past(cfg_d)));
endmodule

// File: rtl/irqp_sof_flag.sv
module irqp_sof_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic sof_pulse,
    input  logic sof_ack,
    output logic sof_flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sof_flag <= 1'b0;
        else if (sof_pulse)
            sof_flag <= 1'b1;
        else if (sof_ack)
            sof_flag <= 1'b0;
    end

    // R6: set wins, including against a simultaneous acknowledge
    assert_sof_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sof_pulse |=> sof_flag);
    assert_sof_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_ack && !sof_pulse) |=> !sof_flag);
    assert_sof_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sof_ack && !sof_pulse) |=> $stable(sof_flag));
endmodule

// File: rtl/irqp_status_or.sv
module irqp_status_or #(
    parameter int N_STATUS = 8
) (
    input  logic [N_STATUS-1:0] pend,
    input  logic [N_STATUS-1:0] en,
    output logic                req
);
    logic [N_STATUS-1:0] live;

    for (genvar g = 0; g < N_STATUS; g++) begin : g_bit
        assign live[g] = pend[g] & en[g];
    end

    always_comb req = |live;

    // R2: a request means some enabled bit is pending
    always_comb begin
        assert_status_or_R2: assert (req == ((pend & en) != '0));
    end
endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
    import irqp_pkg::*;
#(
    parameter int N_STATUS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_STATUS-1:0] status_pend,
    input  logic [N_STATUS-1:0] status_en,
    input  logic                sof_pulse,
    input  logic                sof_ack,
    input  logic                cfg_we,
    input  logic                cfg_sof_only,
    input  logic                cfg_pin_mode,
    output logic                int_n
);
    irq_mode_e  mode;
    logic       sof_flag;
    logic       status_req;
    logic       request;
    pin_state_e state_q, state_d;
    irq_cfg_t   cfg_in;

    always_comb begin
        cfg_in.sof_only = cfg_sof_only;
        cfg_in.pin_mode = cfg_pin_mode;
    end

    irqp_mode_reg u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .cfg_d (cfg_in),
        .mode  (mode)
    );

    irqp_sof_flag u_sof (
        .clk       (clk),
        .rst_n     (rst_n),
        .sof_pulse (sof_pulse),
        .sof_ack   (sof_ack),
        .sof_flag  (sof_flag)
    );

    irqp_status_or #(.N_STATUS(N_STATUS)) u_stat (
        .pend (status_pend),
        .en   (status_en),
        .req  (status_req)
    );

    // source selection by mode
    always_comb begin
        unique case (mode)
            MODE_STATUS: request = status_req;
            MODE_BOTH:   request = status_req | sof_flag;
            MODE_SOF:    request = sof_flag;
            default:     request = 1'b0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= PIN_IDLE;
        else
            state_q <= state_d;
    end

    // transitions RAISE and RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_IDLE:   if (request)  state_d = PIN_ACTIVE;
            PIN_ACTIVE: if (!request) state_d = PIN_IDLE;
            default:    state_d = PIN_IDLE;
        endcase
    end

    // outputs
    always_comb int_n = (state_q != PIN_ACTIVE);

    assert_pin_assert_R7: assert property (@(posedge clk) disable iff (!rst_n)
        request |=> !int_n);
    assert_pin_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !request |=> int_n);
    assert_sof_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SOF && !sof_flag) |=> int_n);
    assert_status_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STATUS && !status_req) |=> int_n);
endmodule

// File: tb/test_irq_pin_ctrl.sv
module test_irq_pin_ctrl;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] status_pend = '0;
    logic [N-1:0] status_en = '0;
    logic         sof_pulse = 1'b0;
    logic         sof_ack = 1'b0;
    logic         cfg_we = 1'b0;
    logic         cfg_sof_only = 1'b0;
    logic         cfg_pin_mode = 1'b0;
    logic         int_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_pin_ctrl #(.N_STATUS(N)) i_irq_pin_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .status_pend  (status_pend),
        .status_en    (status_en),
        .sof_pulse    (sof_pulse),
        .sof_ack      (sof_ack),
        .cfg_we       (cfg_we),
        .cfg_sof_only (cfg_sof_only),
        .cfg_pin_mode (cfg_pin_mode),
        .int_n        (int_n)
    );

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic check(logic exp, string req);
        checks++;
        if (int_n !== exp) begin
            errors++;
            $display("FAIL %s: int_n actual %b expected %b", req, int_n, exp);
        end
    endtask

    task automatic write_cfg(logic so, logic pm);
        cfg_sof_only = so;
        cfg_pin_mode = pm;
        cfg_we = 1'b1;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic pulse_sof();
        sof_pulse = 1'b1;
        tick();
        sof_pulse = 1'b0;
    endtask

    task automatic ack_sof();
        sof_ack = 1'b1;
        tick();
        sof_ack = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(2);
        check(1'b1, "R1");
        rst_n = 1'b1;
        tick();
        check(1'b1, "R1");
        // R1: reset mode is status mode, so an enabled pending bit raises the pin
        status_pend = 8'h01; status_en = 8'h01;
        tick();
        check(1'b0, "R1");
        status_pend = '0;
        tick();
        check(1'b1, "R1");
    endtask

    task automatic t_status_mode();
        status_pend = 8'h04; status_en = 8'h04;
        check(1'b1, "R7");   // not before the edge
        tick();
        check(1'b0, "R7");
        tick(3);
        check(1'b0, "R7");   // held while pending
        status_pend = 8'h08; // pending but masked
        tick();
        check(1'b1, "R2");
        status_pend = 8'h80; status_en = 8'hF0;
        tick();
        check(1'b0, "R2");
        status_pend = '0; status_en = '0;
        tick();
        pulse_sof();         // R9: latched but ignored in status mode (R3)
        tick();
        check(1'b1, "R3");
    endtask

    task automatic t_both_mode();
        write_cfg(1'b0, 1'b1);
        tick();
        check(1'b0, "R9");   // flag from status mode now counts (R4)
        ack_sof();
        tick();
        check(1'b1, "R4");
        status_pend = 8'h02; status_en = 8'h02;
        tick();
        check(1'b0, "R4");
        status_pend = '0;
        tick();
        check(1'b1, "R4");
        // R6: set wins against acknowledge in the same cycle
        sof_pulse = 1'b1; sof_ack = 1'b1;
        tick();
        sof_pulse = 1'b0; sof_ack = 1'b0;
        tick();
        check(1'b0, "R6");
        tick(5);
        check(1'b0, "R6");   // sticky
        ack_sof();
        tick();
        check(1'b1, "R6");
    endtask

    task automatic t_sof_mode();
        for (int pm = 0; pm < 2; pm++) begin
            write_cfg(1'b1, 1'(pm));
            status_pend = 8'hFF; status_en = 8'hFF;
            tick(2);
            check(1'b1, "R5");
            pulse_sof();
            tick();
            check(1'b0, "R5");
            ack_sof();
            tick();
            check(1'b1, "R5");
            status_pend = '0; status_en = '0;
            tick();
        end
        // R8: config inputs without a write have no effect
        cfg_sof_only = 1'b0; cfg_pin_mode = 1'b0;
        status_pend = 8'h10; status_en = 8'h10;
        tick(3);
        check(1'b1, "R8");
        write_cfg(1'b0, 1'b0);
        tick();
        check(1'b0, "R8");
        status_pend = '0; status_en = '0;
        tick();
        check(1'b1, "R8");
    endtask

    initial begin
        tick();
        t_reset();
        t_status_mode();
        t_both_mode();
        t_sof_mode();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule